// File: doc/BRIEF.md
# Round-Robin Chip-Select Distributor

This block takes one periodic, active-low master chip-select and hands each pulse to one of several attached devices in rotation. A small slot counter picks the device. Only the selected select line follows the master chip-select; all other select lines stay high. The counter moves to the next slot when the pulse closes, so routing stays fixed for a whole transfer. A master that sends bursts of a fixed length at a steady rate can then reach every device through one serial port, with no per-transfer work in software.

The selected device's serial data output is routed back to the master. A phase-reset input returns the rotation to slot 0 so that it stays aligned with the master's buffer sequence. A terminal-count flag is high while the last slot is chosen, so firmware can check that it is still in step.

A small state machine follows the transfers. Its states are `ST_IDLE` (master select high), `ST_XFER` (transfer in progress) and `ST_XFER_RST` (transfer in progress with a phase reset waiting). Its transitions are:
- **T_START**: `ST_IDLE` to `ST_XFER` on a falling master select.
- **T_START_RST**: `ST_IDLE` to `ST_XFER_RST` when the master select falls in the same cycle as a phase reset.
- **T_ARM**: `ST_XFER` to `ST_XFER_RST` on a phase reset during a transfer.
- **T_END**: either transfer state back to `ST_IDLE` when the master select rises. From `ST_XFER` this advances the slot. From `ST_XFER_RST` it loads slot 0.

A phase reset seen in `ST_IDLE` while the master select is high loads slot 0 directly.

Top module: `cs_rr_fanout`

## Requirements
- R1: After reset the slot is 0, all select outputs are high, the terminal-count flag is low and the returned data is low, while the master select is high.
- R2: While the master select is low, exactly one select output is low, and its index equals the current slot. While the master select is high, all select outputs are high.
- R3: Each rising edge of the master select without a pending phase reset advances the slot by one, wrapping from N_DEV-1 to 0. The new slot is visible one clock after the rising edge.
- R4: The slot, and therefore the select outputs, do not change while the master select stays low.
- R5: The terminal-count flag is high exactly when the slot is N_DEV-1.
- R6: A phase reset pulse while the master select is high makes the next transfer use slot 0.
- R7: A phase reset that arrives while the master select is low, including in the cycle it falls, does not change the routing of the current transfer. When that transfer ends the slot becomes 0 instead of advancing.
- R8: While the master select is low, the returned data equals the data input of the selected device (bit index = slot). While the master select is high, the returned data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_cs_n_i | input | 1 | Master chip-select, active low |
| phase_rst_i | input | 1 | Synchronous request to return the rotation to slot 0 |
| miso_i | input | N_DEV | Serial data output of each device, bit i from device i |
| sel_n_o | output | N_DEV | Per-device select, active low |
| miso_o | output | 1 | Data returned to the master from the selected device |
| tc_o | output | 1 | High while the last slot is selected |

## Verification
The checks assume that the master select and the phase reset are synchronous to `clk`. They also assume that the master select stays high for at least one full clock between transfers, so the slot update always falls in a gap. The stimulus changes every input on the falling clock edge and keeps each gap at one clock or longer. Phase resets are placed at the start of a transfer, in its middle and in a gap, so that every state transition is exercised.

// File: rtl/cs_rr_pkg.sv
package cs_rr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_XFER     = 2'd1,
        ST_XFER_RST = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/cs_rr_fsm.sv
module cs_rr_fsm
    import cs_rr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic phase_rst,
    output logic adv_o,
    output logic zero_o
);
    xfer_state_e state_q;
    xfer_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n) state_d = phase_rst ? ST_XFER_RST : ST_XFER; // T_START / T_START_RST
            end
            ST_XFER: begin
                if (cs_n)           state_d = ST_IDLE;      // T_END
                else if (phase_rst) state_d = ST_XFER_RST;  // T_ARM
            end
            ST_XFER_RST: begin
                if (cs_n) state_d = ST_IDLE;                // T_END
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        adv_o  = 1'b0;
        zero_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     zero_o = cs_n & phase_rst;
            ST_XFER: begin
                if (cs_n) begin
                    zero_o = phase_rst;
                    adv_o  = ~phase_rst;
                end
            end
            ST_XFER_RST: zero_o = cs_n;
            default: begin
                adv_o  = 1'b0;
                zero_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cs_rr_slot_ctr.sv
module cs_rr_slot_ctr #(
    parameter int N_DEV = 4,
    localparam int W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         zero,
    output logic [W-1:0] slot_o,
    output logic         tc_o
);
    localparam logic [W-1:0] LAST = W'(N_DEV - 1);

    logic [W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst || zero)   slot_q <= '0;
        else if (adv)      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end

    assign slot_o = slot_q;
    assign tc_o   = (slot_q == LAST);
endmodule

// File: rtl/cs_rr_route.sv
module cs_rr_route #(
    parameter int N_DEV = 4,
    localparam int W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             cs_n,
    input  logic [W-1:0]     slot,
    input  logic [N_DEV-1:0] miso_i,
    output logic [N_DEV-1:0] sel_n_o,
    output logic             miso_o
);
    for (genvar i = 0; i < N_DEV; i++) begin : g_sel
        assign sel_n_o[i] = cs_n | (slot != W'(i));
    end

    assign miso_o = ~cs_n & miso_i[slot];
endmodule

// File: rtl/cs_rr_fanout.sv
module cs_rr_fanout #(
    parameter int N_DEV = 4,
    localparam int W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mst_cs_n_i,
    input  logic             phase_rst_i,
    input  logic [N_DEV-1:0] miso_i,
    output logic [N_DEV-1:0] sel_n_o,
    output logic             miso_o,
    output logic             tc_o
);
    logic         adv;
    logic         zero;
    logic [W-1:0] slot;

    cs_rr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (mst_cs_n_i),
        .phase_rst (phase_rst_i),
        .adv_o     (adv),
        .zero_o    (zero)
    );

    cs_rr_slot_ctr #(.N_DEV(N_DEV)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .zero   (zero),
        .slot_o (slot),
        .tc_o   (tc_o)
    );

    cs_rr_route #(.N_DEV(N_DEV)) u_route (
        .cs_n    (mst_cs_n_i),
        .slot    (slot),
        .miso_i  (miso_i),
        .sel_n_o (sel_n_o),
        .miso_o  (miso_o)
    );
endmodule

// File: rtl/cs_rr_fanout_chk.sv
module cs_rr_fanout_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mst_cs_n_i,
    input logic             phase_rst_i,
    input logic [N_DEV-1:0] miso_i,
    input logic [N_DEV-1:0] sel_n_o,
    input logic             miso_o,
    input logic             tc_o
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R2
    one_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !mst_cs_n_i |-> ($countones(~sel_n_o) == 1));

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        mst_cs_n_i |-> (&sel_n_o));

    // R4
    hold_route_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !mst_cs_n_i && !$past(mst_cs_n_i)) |-> (sel_n_o == $past(sel_n_o)));

    // R5
    tc_last_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_o && !mst_cs_n_i) |-> !sel_n_o[N_DEV-1]);

    // R8
    miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mst_cs_n_i |-> !miso_o);

    // R8
    miso_route_chk: assert property (@(posedge clk) disable iff (rst)
        !mst_cs_n_i |-> (miso_o == |(miso_i & ~sel_n_o)));

    // R7
    defer_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !mst_cs_n_i && !$past(mst_cs_n_i) && $past(phase_rst_i))
            |-> $stable(sel_n_o));
endmodule

bind cs_rr_fanout cs_rr_fanout_chk #(.N_DEV(N_DEV)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mst_cs_n_i  (mst_cs_n_i),
    .phase_rst_i (phase_rst_i),
    .miso_i      (miso_i),
    .sel_n_o     (sel_n_o),
    .miso_o      (miso_o),
    .tc_o        (tc_o)
);

// File: tb/cs_rr_fanout_tb.sv
module cs_rr_fanout_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         prst = 1'b0;
    logic [N-1:0] miso = '0;
    logic [N-1:0] sel_n;
    logic         miso_o;
    logic         tc;

    int n_chk = 0;
    int n_bad = 0;
    int exp_slot = 0;

    always #10 clk = ~clk;

    cs_rr_fanout #(.N_DEV(N)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .mst_cs_n_i  (cs_n),
        .phase_rst_i (prst),
        .miso_i      (miso),
        .sel_n_o     (sel_n),
        .miso_o      (miso_o),
        .tc_o        (tc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] onehot_low(input int s);
        return ~(N'(1) << s);
    endfunction

    // pmode: 0 none, 1 phase reset together with falling CS, 2 phase reset mid transfer
    task automatic xfer(input logic [N-1:0] pat, input int pmode);
        @(negedge clk); cs_n = 1'b0; miso = pat; prst = (pmode == 1);
        @(posedge clk); #2;
        chk("R2 select", 32'(sel_n), 32'(onehot_low(exp_slot)));
        chk("R8 miso routed", 32'(miso_o), 32'(pat[exp_slot]));
        chk("R5 tc", 32'(tc), 32'(exp_slot == N-1));
        @(negedge clk); prst = (pmode == 2);
        @(posedge clk); #2;
        chk("R4 hold/R7 defer", 32'(sel_n), 32'(onehot_low(exp_slot)));
        @(negedge clk); prst = 1'b0;
        @(posedge clk); #2;
        chk("R4 hold", 32'(sel_n), 32'(onehot_low(exp_slot)));
        @(negedge clk); cs_n = 1'b1;
        @(posedge clk); #2;
        chk("R2 idle high", 32'(sel_n), 32'(onehot_low(N) | {N{1'b1}}));
        chk("R8 miso quiet", 32'(miso_o), 32'd0);
        exp_slot = (pmode != 0) ? 0 : (exp_slot + 1) % N;
        chk((pmode != 0) ? "R7 tc after defer" : "R3 tc after step", 32'(tc), 32'(exp_slot == N-1));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        chk("R1 sel", 32'(sel_n), 32'({N{1'b1}}));
        chk("R1 tc", 32'(tc), 32'd0);
        chk("R1 miso", 32'(miso_o), 32'd0);
        exp_slot = 0;
    endtask

    task automatic t_rotation();
        for (int k = 0; k < 6; k++) xfer(N'(4'b1010 ^ k), 0);  // R3 wraps past N-1
    endtask

    task automatic t_miso();
        xfer(4'b1111, 0);
        xfer(4'b0000, 0);
        xfer(N'(1) << exp_slot, 0);       // R8 only selected bit set
        xfer(~(N'(1) << exp_slot), 0);    // R8 only selected bit clear
    endtask

    task automatic t_phase_idle();
        xfer(4'b0110, 0);
        @(negedge clk); prst = 1'b1;
        @(negedge clk); prst = 1'b0;
        @(posedge clk); #2;
        chk("R6 sel idle", 32'(sel_n), 32'({N{1'b1}}));
        chk("R6 tc", 32'(tc), 32'd0);
        exp_slot = 0;
        xfer(4'b0001, 0);  // R6 lands on slot 0
    endtask

    task automatic t_phase_busy();
        xfer(4'b0101, 0);
        xfer(4'b1100, 2);  // R7 mid transfer
        xfer(4'b0011, 0);
    endtask

    task automatic t_phase_start();
        xfer(4'b1001, 0);
        xfer(4'b1110, 0);
        xfer(4'b0111, 1);  // R7 with falling CS
        xfer(4'b1011, 0);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rotation();
        t_miso();
        t_phase_idle();
        t_phase_busy();
        t_phase_start();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule